// File: doc/BRIEF.md
# Framed Serial Configuration Loader

The loader takes a fixed-length frame from a host controller over three wires: a serial data line, a serial clock and an enable line. Each frame carries a short control prefix that selects how a downstream radio encoder works, followed by a 128-bit payload. The three host lines are asynchronous to the system clock. They are synchronised and oversampled, and a data bit is taken on each falling edge of the serial clock while the enable line is high.

When the enable line falls, the loader checks the frame. The frame is accepted only if exactly 134 bits arrived and the band code in the prefix is legal. An accepted frame updates the decoded control outputs and the payload register, and it raises a one-cycle start strobe. Any other frame is dropped and raises a one-cycle error strobe. A dropped frame leaves the previously accepted configuration untouched.

Top module: `cfg_frame_loader`

## Requirements
- R1: After reset all decoded outputs, the payload register and both strobes are zero.
- R2: A bit is taken only on a falling edge of the serial clock while the enable line is high. Falling edges while enable is low have no effect on the outputs or on the count of the next frame.
- R3: When enable falls after exactly 134 captured bits and the band code is legal, `frame_ok_o` pulses high for one cycle, and the outputs take the new frame in that same cycle.
- R4: The six prefix bits are sent first. In order of arrival they drive `cfg_xtal_o`, `cfg_range_o`, `cfg_duty_o`, `cfg_cont_o`, `cfg_gp_o[1]` and `cfg_gp_o[0]`.
- R5: The payload is sent MSB-first. The first payload bit lands in `payload_o[127]` and the last lands in `payload_o[0]`.
- R6: `band_o` encodes the band as follows: 0 when xtal=1 and range=0, 1 when xtal=0 and range=0, 2 when xtal=0 and range=1.
- R7: If enable falls with any bit count other than 134 (shorter, longer or zero), `frame_err_o` pulses for one cycle, `frame_ok_o` stays low and all outputs keep their previous values.
- R8: A frame whose first two prefix bits are both 1 is rejected in the same way as R7.
- R9: `frame_ok_o` and `frame_err_o` are never high together, and each is high for at most one cycle in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Host serial clock, sampled on its falling edge |
| ser_dat_i | input | 1 | Host serial data |
| ser_en_i | input | 1 | Host frame enable, high for the whole frame |
| cfg_xtal_o | output | 1 | Crystal select from prefix bit 1 |
| cfg_range_o | output | 1 | Range select from prefix bit 2 |
| cfg_duty_o | output | 1 | Duty-cycle enable from prefix bit 3 |
| cfg_cont_o | output | 1 | Continuous (1) or single (0) transmission |
| cfg_gp_o | output | 2 | General-purpose prefix bits 5 and 6 |
| band_o | output | 2 | Decoded band code |
| payload_o | output | 128 | Last accepted payload |
| frame_ok_o | output | 1 | One-cycle start strobe for an accepted frame |
| frame_err_o | output | 1 | One-cycle strobe for a rejected frame |

## Verification
The assertions check on every cycle the properties that need no knowledge of the frame contents:

- the two strobes are exclusive and each lasts one cycle;
- a strobe only follows a detected enable fall;
- an accepted frame always had exactly 134 bits counted and never carries the illegal band code;
- the payload holds still whenever an error is flagged.

Only the bench scenarios can show the following:

- the arrival order of the bits and how they map onto the fields and the payload;
- the band code mapping;
- that clock edges outside the enable window are ignored;
- that short, long and illegal-band frames preserve the earlier configuration.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

  localparam int CTRL_BITS = 6;

  typedef enum logic [1:0] {
    BAND_LOW  = 2'd0,
    BAND_MID  = 2'd1,
    BAND_HIGH = 2'd2,
    BAND_NONE = 2'd3
  } band_e;

  // Field order matches arrival order: the first bit received is the MSB.
  typedef struct packed {
    logic       xtal;
    logic       range_hi;
    logic       duty;
    logic       cont;
    logic [1:0] gp;
  } ctrl_t;

  function automatic band_e band_of(input logic xtal, input logic range_hi);
    case ({xtal, range_hi})
      2'b10:   return BAND_LOW;
      2'b00:   return BAND_MID;
      2'b01:   return BAND_HIGH;
      default: return BAND_NONE;
    endcase
  endfunction

  function automatic logic band_legal(input logic xtal, input logic range_hi);
    return !(xtal && range_hi);
  endfunction

endpackage

// File: rtl/cfgload_sync.sv
module cfgload_sync #(
  parameter int W           = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [SYNC_STAGES:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[SYNC_STAGES-1:0], d_i};
  end

  assign q_o      = pipe[SYNC_STAGES-1];
  assign q_prev_o = pipe[SYNC_STAGES];
endmodule

// File: rtl/cfgload_shifter.sv
module cfgload_shifter #(
  parameter int FRAME_BITS = 134,
  parameter int CNT_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_i,
  input  logic                  fall_i,
  input  logic                  dat_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic [CNT_W-1:0]      count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_o <= '0;
      count_o <= '0;
    end else if (!en_i) begin
      count_o <= '0;
    end else if (fall_i) begin
      frame_o <= {frame_o[FRAME_BITS-2:0], dat_i};
      if (count_o != CNT_MAX) count_o <= count_o + 1'b1;
    end
  end
endmodule

// File: rtl/cfgload_decode.sv
module cfgload_decode
  import cfgload_pkg::*;
#(
  parameter int PAYLOAD_BITS = 128,
  parameter int FRAME_BITS   = CTRL_BITS + PAYLOAD_BITS,
  parameter int CNT_W        = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    close_i,
  input  logic [CNT_W-1:0]        count_i,
  input  logic [FRAME_BITS-1:0]   frame_i,
  output ctrl_t                   ctrl_o,
  output band_e                   band_o,
  output logic [PAYLOAD_BITS-1:0] payload_o,
  output logic                    ok_o,
  output logic                    err_o
);
  ctrl_t ctrl_w;
  logic  count_ok_w;
  logic  accept_w;

  assign ctrl_w     = ctrl_t'(frame_i[FRAME_BITS-1 -: CTRL_BITS]);
  assign count_ok_w = (count_i == CNT_W'(FRAME_BITS));
  assign accept_w   = close_i && count_ok_w && band_legal(ctrl_w.xtal, ctrl_w.range_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o    <= '0;
      band_o    <= BAND_LOW;
      payload_o <= '0;
      ok_o      <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      ok_o  <= accept_w;
      err_o <= close_i && !accept_w;
      if (accept_w) begin
        ctrl_o    <= ctrl_w;
        band_o    <= band_of(ctrl_w.xtal, ctrl_w.range_hi);
        payload_o <= frame_i[PAYLOAD_BITS-1:0];
      end
    end
  end
endmodule

// File: rtl/cfg_frame_loader.sv
module cfg_frame_loader
  import cfgload_pkg::*;
#(
  parameter int PAYLOAD_BITS = 128,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ser_clk_i,
  input  logic                    ser_dat_i,
  input  logic                    ser_en_i,
  output logic                    cfg_xtal_o,
  output logic                    cfg_range_o,
  output logic                    cfg_duty_o,
  output logic                    cfg_cont_o,
  output logic [1:0]              cfg_gp_o,
  output logic [1:0]              band_o,
  output logic [PAYLOAD_BITS-1:0] payload_o,
  output logic                    frame_ok_o,
  output logic                    frame_err_o
);
  localparam int FRAME_BITS = CTRL_BITS + PAYLOAD_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  // Synchronised lines: bit 2 = enable, bit 1 = serial clock, bit 0 = data.
  logic [2:0] cur_w, prev_w;
  logic       sclk_fall_w;
  logic       en_fall_w;
  logic       en_w;

  logic [FRAME_BITS-1:0] frame_w;
  logic [CNT_W-1:0]      bit_count_w;
  ctrl_t                 ctrl_w;
  band_e                 band_w;

  cfgload_sync #(.W(3), .SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_i      ({ser_en_i, ser_clk_i, ser_dat_i}),
    .q_o      (cur_w),
    .q_prev_o (prev_w)
  );

  assign en_w        = cur_w[2];
  assign sclk_fall_w = prev_w[1] && !cur_w[1];
  assign en_fall_w   = prev_w[2] && !cur_w[2];

  cfgload_shifter #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) i_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_w),
    .fall_i  (sclk_fall_w),
    .dat_i   (cur_w[0]),
    .frame_o (frame_w),
    .count_o (bit_count_w)
  );

  cfgload_decode #(
    .PAYLOAD_BITS (PAYLOAD_BITS),
    .FRAME_BITS   (FRAME_BITS),
    .CNT_W        (CNT_W)
  ) i_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .close_i   (en_fall_w),
    .count_i   (bit_count_w),
    .frame_i   (frame_w),
    .ctrl_o    (ctrl_w),
    .band_o    (band_w),
    .payload_o (payload_o),
    .ok_o      (frame_ok_o),
    .err_o     (frame_err_o)
  );

  assign cfg_xtal_o  = ctrl_w.xtal;
  assign cfg_range_o = ctrl_w.range_hi;
  assign cfg_duty_o  = ctrl_w.duty;
  assign cfg_cont_o  = ctrl_w.cont;
  assign cfg_gp_o    = ctrl_w.gp;
  assign band_o      = band_w;
endmodule

// File: rtl/cfg_frame_loader_chk.sv
module cfg_frame_loader_chk #(
  parameter int PAYLOAD_BITS = 128,
  parameter int FRAME_BITS   = 134,
  parameter int CNT_W        = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    frame_ok,
  input logic                    frame_err,
  input logic                    en_fall,
  input logic [CNT_W-1:0]        bit_count,
  input logic                    cfg_xtal,
  input logic                    cfg_range,
  input logic [PAYLOAD_BITS-1:0] payload
);
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && frame_err)); // R9
  AST_OK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok); // R9
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err); // R9
  AST_OK_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> $past(en_fall)); // R3
  AST_ERR_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(en_fall)); // R7
  AST_OK_EXACT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> ($past(bit_count) == CNT_W'(FRAME_BITS))); // R3
  AST_OK_LEGAL_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> !(cfg_xtal && cfg_range)); // R8
  AST_ERR_HOLDS_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $stable(payload)); // R7
endmodule

bind cfg_frame_loader cfg_frame_loader_chk #(
  .PAYLOAD_BITS (PAYLOAD_BITS),
  .FRAME_BITS   (FRAME_BITS),
  .CNT_W        (CNT_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_ok  (frame_ok_o),
  .frame_err (frame_err_o),
  .en_fall   (en_fall_w),
  .bit_count (bit_count_w),
  .cfg_xtal  (cfg_xtal_o),
  .cfg_range (cfg_range_o),
  .payload   (payload_o)
);

// File: tb/test_cfg_frame_loader.sv
module test_cfg_frame_loader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;
  localparam int NBITS      = 134;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_clk = 1'b1;
  logic         ser_dat = 1'b0;
  logic         ser_en = 1'b0;
  logic         cfg_xtal, cfg_range, cfg_duty, cfg_cont;
  logic [1:0]   cfg_gp, band;
  logic [127:0] payload;
  logic         frame_ok, frame_err;

  int checks = 0;
  int errs = 0;
  int ok_cnt = 0;
  int err_cnt = 0;
  int both_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_frame_loader i_cfg_frame_loader (
    .clk (clk), .rst_n (rst_n),
    .ser_clk_i (ser_clk), .ser_dat_i (ser_dat), .ser_en_i (ser_en),
    .cfg_xtal_o (cfg_xtal), .cfg_range_o (cfg_range), .cfg_duty_o (cfg_duty),
    .cfg_cont_o (cfg_cont), .cfg_gp_o (cfg_gp), .band_o (band),
    .payload_o (payload), .frame_ok_o (frame_ok), .frame_err_o (frame_err)
  );

  always @(posedge clk) begin
    if (frame_ok)  ok_cnt++;
    if (frame_err) err_cnt++;
    if (frame_ok && frame_err) both_cnt++;
  end

  task automatic chk(input bit cond, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!cond) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Band code expected from the requirement table.
  function automatic logic [1:0] exp_band(input logic x, input logic r);
    if (x && !r)  return 2'd0;
    if (!x && !r) return 2'd1;
    return 2'd2;
  endfunction

  // Sends nbits of {ctrl, pay}, first bit first; bits past the frame are zero.
  task automatic send(input logic [5:0] ctrl, input logic [127:0] pay, input int nbits);
    logic [133:0] f;
    f = {ctrl, pay};
    @(negedge clk);
    ser_en = 1'b1;
    repeat (HALF_BIT) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = (i < NBITS) ? f[NBITS-1-i] : 1'b0;
      ser_clk = 1'b1;
      repeat (HALF_BIT) @(negedge clk);
      ser_clk = 1'b0;
      repeat (HALF_BIT) @(negedge clk);
    end
    ser_clk = 1'b1;
    repeat (HALF_BIT) @(negedge clk);
    ser_en = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    chk({cfg_xtal, cfg_range, cfg_duty, cfg_cont, cfg_gp, band} == 0, "R1 fields",
        {cfg_xtal, cfg_range, cfg_duty, cfg_cont, cfg_gp, band}, 0);
    chk(payload == 0, "R1 payload", payload, 0);
    chk(ok_cnt == 0 && err_cnt == 0, "R1 strobes", ok_cnt + err_cnt, 0);
  endtask

  task automatic t_good(input logic [5:0] ctrl, input logic [127:0] pay);
    int o0, e0;
    o0 = ok_cnt; e0 = err_cnt;
    send(ctrl, pay, NBITS);
    chk(ok_cnt == o0 + 1 && err_cnt == e0, "R3 accept strobe", ok_cnt - o0, 1);
    chk({cfg_xtal, cfg_range, cfg_duty, cfg_cont, cfg_gp} == ctrl, "R4 field order",
        {cfg_xtal, cfg_range, cfg_duty, cfg_cont, cfg_gp}, ctrl);
    chk(payload == pay, "R5 payload order", payload, pay);
    chk(band == exp_band(ctrl[5], ctrl[4]), "R6 band code", band, exp_band(ctrl[5], ctrl[4]));
  endtask

  task automatic t_bad(input logic [5:0] ctrl, input int nbits, input string req);
    int o0, e0;
    logic [127:0] p0;
    logic [7:0]   f0;
    o0 = ok_cnt; e0 = err_cnt; p0 = payload;
    f0 = {cfg_xtal, cfg_range, cfg_duty, cfg_cont, cfg_gp, band};
    send(ctrl, ~p0, nbits);
    chk(err_cnt == e0 + 1 && ok_cnt == o0, req, err_cnt - e0, 1);
    chk(payload == p0, req, payload, p0);
    chk({cfg_xtal, cfg_range, cfg_duty, cfg_cont, cfg_gp, band} == f0, req,
        {cfg_xtal, cfg_range, cfg_duty, cfg_cont, cfg_gp, band}, f0);
  endtask

  task automatic t_idle_edges();
    int o0, e0;
    logic [127:0] p0;
    o0 = ok_cnt; e0 = err_cnt; p0 = payload;
    for (int i = 0; i < 10; i++) begin
      ser_dat = i[0];
      ser_clk = 1'b0; repeat (HALF_BIT) @(negedge clk);
      ser_clk = 1'b1; repeat (HALF_BIT) @(negedge clk);
    end
    chk(ok_cnt == o0 && err_cnt == e0, "R2 idle edges strobe", ok_cnt + err_cnt, o0 + e0);
    chk(payload == p0, "R2 idle edges payload", payload, p0);
    t_good(6'b000111, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210); // R2 count unaffected
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_good(6'b010110, 128'hA5A5_5A5A_DEAD_BEEF_0F0F_F0F0_1234_5678);
    t_good(6'b100001, {1'b1, 127'd0});
    t_good(6'b001010, 128'd1);
    t_bad(6'b000000, 133, "R7 short frame");
    t_bad(6'b000000, 135, "R7 long frame");
    t_bad(6'b000000, 0, "R7 empty frame");
    t_bad(6'b110101, NBITS, "R8 illegal band");
    t_idle_edges();
    chk(both_cnt == 0, "R9 exclusive strobes", both_cnt, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule